// File: doc/BRIEF.md
# Shared Data/Reset Pin Warm-Reset Detector

This block watches a serial-memory pad that serves either as the fourth data line or as an active-low warm-reset input. It decides when a low level on that pad is a genuine reset request and not data traffic. It then emits a one-clock reset pulse. It also reports to the I/O logic whether the pad currently plays the data role or the reset role.

A function-select bit enables the reset role. When this bit is clear, the pad is data or hold and no reset is ever produced. In four-line mode, the pad carries data while the chip is selected. Its level only counts as a reset request while the chip is deselected, and only after a settling window that starts when chip select rises. In every mode, the low level must last a programmable minimum number of cycles before a reset is declared.

Chip select and the pad are resynchronised to the block clock before use. The function-select and four-line bits are static configuration and are not synchronised.

Top module: `mio_rst_detect`

## Requirements
- R1: While rst_ni is low and in the first cycle after it, rst_pulse_o is 0. The synchronised chip select resets to deselected and the synchronised pad resets to high.
- R2: With alt_rst_en_i = 0, rst_pulse_o stays 0 for any pad level, and pin_is_rst_o is 0.
- R3: pin_is_rst_o is 1 (reset role) when alt_rst_en_i = 1 and either quad_en_i = 0 or the synchronised chip select is deselected (cs_n_i = 1). Otherwise it is 0 (data role). A cs_n_i change reaches it two clock edges later.
- R4: With quad_en_i = 1 and cs_n_i = 0, pad activity never produces a pulse.
- R5: With alt_rst_en_i = 1 and cs_n_i = 1, a pad low for at least RP_CYC sampled cycles produces exactly one pulse. The pulse is visible after the (RP_CYC+2)-th rising edge that follows the first edge sampling the pad low.
- R6: A pad low for fewer than RP_CYC cycles produces no pulse.
- R7: With quad_en_i = 1, the pad is ignored for BLANK_CYC cycles after the synchronised chip select rises. A low held from the rise needs BLANK_CYC+RP_CYC cycles to fire; BLANK_CYC+RP_CYC-1 cycles do not fire.
- R8: rst_pulse_o is high for one cycle only. It does not fire again until the pad has been sampled high.
- R9: The low-time count restarts whenever the pad is sampled high or chip select is sampled low, so two short low runs never add up.
- R10: With quad_en_i = 0 there is no settling window. A low that starts together with the chip-select rise and lasts RP_CYC cycles fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select level, low = selected |
| pin_i | input | 1 | Sampled level of the shared data/reset pad |
| alt_rst_en_i | input | 1 | 1 = pad alternate function is reset, 0 = hold |
| quad_en_i | input | 1 | 1 = four-line data mode enabled |
| pin_is_rst_o | output | 1 | 1 = pad is a reset input now, 0 = data line |
| rst_pulse_o | output | 1 | One-cycle warm-reset request |

## Verification
A pad or chip-select change passes two synchroniser flops, so pin_is_rst_o follows cs_n_i after two edges. With RP_CYC=8, a qualifying low shows rst_pulse_o after RP_CYC+2 edges; in four-line mode, BLANK_CYC more edges are needed after the chip-select rise. Stimulus is applied one time unit after a falling edge, and outputs are sampled at the same point, one half period after the rising edge that updates them. The exact-cycle check samples the pulse at RP_CYC+1 and RP_CYC+2 falling edges after the drive. Other scenarios count pulses over a window that closes well after the longest latency and compare the count with the value the requirement predicts.

// File: rtl/mio_rst_pkg.sv
package mio_rst_pkg;

  typedef enum logic {
    PIN_DATA  = 1'b0,
    PIN_RESET = 1'b1
  } pin_role_e;

  function automatic pin_role_e role_of(input logic alt_en, input logic quad_en,
                                        input logic cs_hi);
    return (alt_en && (!quad_en || cs_hi)) ? PIN_RESET : PIN_DATA;
  endfunction

endpackage

// File: rtl/mio_sync_cell.sv
module mio_sync_cell #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/mio_blank_win.sv
module mio_blank_win #(
  parameter int unsigned BLANK_CYC = 4,
  localparam int unsigned CW = $clog2(BLANK_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_hi_i,
  input  logic quad_i,
  output logic blank_o
);

  logic [CW-1:0] hi_cnt_q;

  // counts cycles since deselect, saturating at the window length
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           hi_cnt_q <= CW'(BLANK_CYC);
    else if (!cs_hi_i)                     hi_cnt_q <= '0;
    else if (hi_cnt_q < CW'(BLANK_CYC))    hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  assign blank_o = quad_i && cs_hi_i && (hi_cnt_q < CW'(BLANK_CYC));

  a_r7_blank_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (BLANK_CYC > 0 && quad_i && cs_hi_i && $past(!cs_hi_i)) |-> blank_o);

  a_r7_cnt_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_cnt_q <= CW'(BLANK_CYC));

endmodule

// File: rtl/mio_low_qual.sv
module mio_low_qual #(
  parameter int unsigned RP_CYC = 8,
  localparam int unsigned CW = $clog2(RP_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic armed_i,
  input  logic pin_hi_i,
  output logic fire_o
);

  logic [CW-1:0] low_cnt_q;
  logic          spent_q;
  logic          hit;

  assign hit = armed_i && !pin_hi_i && !spent_q && (low_cnt_q == CW'(RP_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       low_cnt_q <= '0;
    else if (!armed_i || pin_hi_i)     low_cnt_q <= '0;
    else if (low_cnt_q < CW'(RP_CYC))  low_cnt_q <= low_cnt_q + 1'b1;
  end

  // one pulse per low run; re-arm only after the pad reads high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spent_q <= 1'b0;
      fire_o  <= 1'b0;
    end else begin
      fire_o <= hit;
      if (pin_hi_i) spent_q <= 1'b0;
      else if (hit) spent_q <= 1'b1;
    end
  end

  a_r8_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o);

  a_r8_no_refire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spent_q && !pin_hi_i) |=> !fire_o);

  a_r9_fire_needs_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> $past(!pin_hi_i && armed_i));

endmodule

// File: rtl/mio_rst_detect.sv
module mio_rst_detect
  import mio_rst_pkg::*;
#(
  parameter int unsigned RP_CYC      = 8,
  parameter int unsigned BLANK_CYC   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_i,
  input  logic pin_i,
  input  logic alt_rst_en_i,
  input  logic quad_en_i,
  output logic pin_is_rst_o,
  output logic rst_pulse_o
);

  logic [1:0] sync_q;
  logic       cs_hi_s;
  logic       pin_hi_s;
  logic       blank;
  logic       armed;
  pin_role_e  role;

  // deselected and pulled-up after reset
  mio_sync_cell #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES),
    .RST_VAL(2'b11)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_n_i, pin_i}),
    .q_o   (sync_q)
  );

  assign cs_hi_s  = sync_q[1];
  assign pin_hi_s = sync_q[0];

  mio_blank_win #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_hi_i(cs_hi_s),
    .quad_i (quad_en_i),
    .blank_o(blank)
  );

  assign role         = role_of(alt_rst_en_i, quad_en_i, cs_hi_s);
  assign pin_is_rst_o = (role == PIN_RESET);
  assign armed        = alt_rst_en_i && cs_hi_s && !blank;

  mio_low_qual #(.RP_CYC(RP_CYC)) u_qual (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .armed_i (armed),
    .pin_hi_i(pin_hi_s),
    .fire_o  (rst_pulse_o)
  );

  a_r2_no_fire_hold_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pulse_o |-> $past(alt_rst_en_i));

  a_r4_no_fire_selected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pulse_o |-> $past(cs_hi_s));

  a_r7_no_fire_in_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pulse_o |-> $past(!blank));

  a_r3_data_role_selected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quad_en_i && !cs_hi_s) |-> !pin_is_rst_o);

endmodule

// File: tb/sim_mio_rst_detect.sv
module sim_mio_rst_detect;

  localparam int RP = 8;
  localparam int BL = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_n = 1'b1, pin = 1'b1, alt = 1'b1, quad = 1'b1;
  logic pin_is_rst, pulse;

  int checks = 0, errors = 0, pulse_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mio_rst_detect #(.RP_CYC(RP), .BLANK_CYC(BL), .SYNC_STAGES(2)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cs_n_i(cs_n), .pin_i(pin),
    .alt_rst_en_i(alt), .quad_en_i(quad),
    .pin_is_rst_o(pin_is_rst), .rst_pulse_o(pulse)
  );

  always @(negedge clk) if (pulse) pulse_cnt++;

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_pulses(input int low_len, input int need);
    return (low_len >= need) ? 1 : 0;
  endfunction

  // low run of n cycles, then high and settle; returns pulses seen
  task automatic low_run(input int n, output int got);
    int base;
    base = pulse_cnt;
    pin = 1'b0;
    step(n);
    pin = 1'b1;
    step(RP + 6);
    got = pulse_cnt - base;
  endtask

  initial begin
    int got, base, n;
    void'($urandom(32'd2024));
    step(3);
    chk("R1 pulse in reset", pulse, 0);
    rst_ni = 1'b1;
    step(1);
    chk("R1 pulse after reset", pulse, 0);
    chk("R1 role after reset (deselected)", pin_is_rst, 1);

    // R2 hold function: never a reset
    alt = 1'b0; quad = 1'b0;
    step(1);
    chk("R2 role hold mode", pin_is_rst, 0);
    low_run(3 * RP, got);
    chk("R2 no pulse in hold mode", got, 0);

    // R3 role flag with two-edge synchroniser delay
    alt = 1'b1; quad = 1'b1; cs_n = 1'b0;
    step(3);
    chk("R3 role selected quad", pin_is_rst, 0);
    cs_n = 1'b1;
    step(1);
    chk("R3 role one edge after deselect", pin_is_rst, 0);
    step(1);
    chk("R3 role two edges after deselect", pin_is_rst, 1);
    quad = 1'b0; cs_n = 1'b0;
    step(3);
    chk("R3 role non-quad selected", pin_is_rst, 1);
    cs_n = 1'b1;
    step(BL + 3);

    // R5 exact latency, R8 single pulse during long low
    base = pulse_cnt;
    pin = 1'b0;
    step(RP + 1);
    chk("R5 no pulse before due", pulse, 0);
    step(1);
    chk("R5 pulse due", pulse, 1);
    step(1);
    chk("R8 pulse one cycle", pulse, 0);
    step(3 * RP);
    chk("R8 no refire while low", pulse_cnt - base, 1);
    pin = 1'b1;
    step(RP);
    low_run(RP, got);
    chk("R8 rearmed after high", got, 1);

    // R6 short low
    low_run(RP - 1, got);
    chk("R6 short low no pulse", got, 0);

    // R9 runs split by a high cycle or a select cycle
    base = pulse_cnt;
    pin = 1'b0; step(RP - 2);
    pin = 1'b1; step(1);
    pin = 1'b0; step(RP - 2);
    pin = 1'b1; step(RP + 6);
    chk("R9 split by high", pulse_cnt - base, 0);
    base = pulse_cnt;
    pin = 1'b0; step(RP - 2);
    cs_n = 1'b0; step(1);
    cs_n = 1'b1; step(RP - 2);
    pin = 1'b1; step(RP + 6);
    chk("R9 split by select", pulse_cnt - base, 0);

    // R5/R6 random run lengths, non-quad
    for (int t = 0; t < 24; t++) begin
      n = $urandom_range(1, 2 * RP);
      low_run(n, got);
      chk($sformatf("R5 R6 random low len %0d", n), got, exp_pulses(n, RP));
    end

    // R4 data toggling while selected in quad mode
    quad = 1'b1; cs_n = 1'b0;
    step(3);
    base = pulse_cnt;
    for (int i = 0; i < 300; i++) begin
      pin = (i % 50 < 20) ? 1'b0 : 1'($urandom_range(0, 1));
      step(1);
    end
    pin = 1'b1;
    step(2);
    cs_n = 1'b1;
    step(BL + RP + 6);
    chk("R4 no pulse while selected", pulse_cnt - base, 0);

    // R7 low from the deselect edge, blanking boundary
    cs_n = 1'b0; step(4);
    base = pulse_cnt;
    cs_n = 1'b1; pin = 1'b0;
    step(BL + RP - 1);
    pin = 1'b1; step(RP + 6);
    chk("R7 blank plus short", pulse_cnt - base, 0);
    cs_n = 1'b0; step(4);
    base = pulse_cnt;
    cs_n = 1'b1; pin = 1'b0;
    step(BL + RP);
    pin = 1'b1; step(RP + 6);
    chk("R7 blank plus full", pulse_cnt - base, 1);
    cs_n = 1'b0; step(4);
    base = pulse_cnt;
    cs_n = 1'b1; pin = 1'b0;
    step(BL);
    pin = 1'b1; step(RP + 6);
    chk("R7 low only in window", pulse_cnt - base, 0);

    // R10 no blanking in non-quad mode
    quad = 1'b0;
    cs_n = 1'b0; step(4);
    base = pulse_cnt;
    cs_n = 1'b1; pin = 1'b0;
    step(RP);
    pin = 1'b1; step(RP + 6);
    chk("R10 non-quad fires without window", pulse_cnt - base, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule